// File: doc/BRIEF.md
# Timing-Wheel Event Scheduler

This block delays event tokens by a programmable number of time units. A client presents an event identifier together with a delay. The scheduler files the identifier in a slot of a circular wheel, and hands it back on a valid/ready output once the time base has advanced past that slot. The wheel has `NUM_SLOTS` slots. Each slot is a small list that holds up to `SLOT_CAP` identifiers. A slot is emptied after its last identifier has been handed out.

The time base is not a plain cycle counter. It is the sum of `NUM_KINDS` separate activity counters. Each counter advances by one on a pulse of its own `tick_i` bit. Several bits may pulse in the same clock cycle, so time can jump by more than one unit in a cycle. For that reason the scheduler keeps a service pointer to the last slot it has fully serviced. It walks that pointer forward one slot at a time until it reaches the current slot, wrapping from the top of the wheel to slot 0. Every slot crossed on the way is drained, so no slot is skipped.

The walk is run by a four-state controller:

- IDLE waits for work.
- LOAD selects the next slot and reads its fill level.
- EMIT presents the entries of that slot one per accepted handshake.
- CLEAR empties the slot and moves the service pointer onto it.

The transitions are:

- IDLE→LOAD when events are pending and the service pointer differs from the current slot.
- LOAD→EMIT when the selected slot holds entries.
- LOAD→CLEAR when the selected slot is empty.
- EMIT→CLEAR on the handshake of the slot's last entry.
- CLEAR→IDLE unconditionally.

While the wheel holds no events, IDLE keeps the service pointer equal to the current slot. This samples the time afresh for the first request after an idle period.

Top module: `timing_wheel_sched`

## Requirements
- R1: After reset, `fire_valid_o`, `err_full_o` and `err_zero_o` are 0 and `time_o` is 0.
- R2: `time_o` equals the sum of the per-kind counters. Each set bit of `tick_i` in a cycle adds one to its counter, so several set bits in one cycle add that many units. The current slot is `time_o` modulo `NUM_SLOTS`.
- R3: An accepted request is stored in slot (base + delay) mod `NUM_SLOTS`. The base depends on the controller state and on whether events are pending:
  - In IDLE with no events pending, the base is the current slot.
  - In IDLE with events pending, the base is the service pointer.
  - In LOAD, EMIT and CLEAR, the base is the slot being drained.
- R4: An identifier scheduled with delay d from a settled wheel (service pointer equal to the current slot) is emitted exactly once. This happens after time has advanced by d units and not before.
- R5: When time jumps across several slots, every crossed slot is drained in ascending slot order. This includes crossings that wrap from slot `NUM_SLOTS-1` to slot 0. A slot beyond the current slot is not drained.
- R6: At most one identifier leaves per cycle. While `fire_valid_o` is 1 and `fire_ready_i` is 0, `fire_valid_o` stays 1 and `fire_id_o` holds its value.
- R7: The entries of one slot leave in the order they were scheduled. After they have left, the slot is empty, and a later pass over it emits nothing.
- R8: A request (nonzero delay) whose target slot already holds `SLOT_CAP` entries is dropped. `err_full_o` pulses high in the cycle after the request.
- R9: A request with delay 0 is dropped and never emitted. `err_zero_o` pulses high in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | NUM_KINDS | One activity pulse per counter kind |
| sched_valid_i | input | 1 | Schedule request strobe, one request per cycle |
| sched_id_i | input | ID_W | Identifier to schedule |
| sched_delay_i | input | $clog2(NUM_SLOTS) | Delay in time units, 1 to NUM_SLOTS-1 |
| err_full_o | output | 1 | Request dropped: target slot full |
| err_zero_o | output | 1 | Request dropped: delay was zero |
| fire_valid_o | output | 1 | An identifier is being presented |
| fire_id_o | output | ID_W | Presented identifier |
| fire_ready_i | input | 1 | Consumer accepts the presented identifier |
| time_o | output | CNT_W | Current time base (sum of counters) |

## Verification
The assertions watch several properties on every cycle:

- The output holds steady under backpressure.
- Each error pulse can be traced to a request of the matching kind one cycle earlier.
- The two error flags never assert together.
- Nothing is presented while the wheel is empty.
- Each handshake lowers the stored-event count by one.

Some behaviour only the bench scenarios can show:

- Each identifier leaves at the right time step.
- Crossed slots drain in order across the wrap point.
- Entries of a slot keep their scheduling order.
- Dropped and emptied entries never reappear during a full later revolution of the wheel.

// File: rtl/tw_pkg.sv
package tw_pkg;

    // Controller states of the wheel service walk.
    typedef enum logic [1:0] {
        TW_IDLE  = 2'd0,
        TW_LOAD  = 2'd1,
        TW_EMIT  = 2'd2,
        TW_CLEAR = 2'd3
    } tw_state_e;

endpackage

// File: rtl/tw_timebase.sv
// Sum of several per-kind activity counters; the low bits give the slot.
module tw_timebase #(
    parameter int NUM_KINDS = 5,
    parameter int CNT_W     = 32,
    parameter int SLOT_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_KINDS-1:0] tick_i,
    output logic [CNT_W-1:0]     time_o,
    output logic [SLOT_W-1:0]    now_slot_o
);

    logic [CNT_W-1:0] kind_cnt [NUM_KINDS];

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                kind_cnt[k] <= '0;
            end else if (tick_i[k]) begin
                kind_cnt[k] <= kind_cnt[k] + 1'b1;
            end
        end
    end

    always_comb begin
        time_o = '0;
        for (int k = 0; k < NUM_KINDS; k++) begin
            time_o = time_o + kind_cnt[k];
        end
    end

    assign now_slot_o = time_o[SLOT_W-1:0];

endmodule

// File: rtl/tw_slot_store.sv
// Per-slot fixed-capacity lists: append on write, wipe on clear.
module tw_slot_store #(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_CAP  = 4,
    parameter int ID_W      = 8,
    parameter int SLOT_W    = 4,
    parameter int IDX_W     = 2,
    parameter int CNTF_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [SLOT_W-1:0] wr_slot_i,
    input  logic [ID_W-1:0]   wr_id_i,
    output logic [CNTF_W-1:0] wr_cnt_o,
    input  logic              clr_en_i,
    input  logic [SLOT_W-1:0] clr_slot_i,
    input  logic [SLOT_W-1:0] rd_slot_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [ID_W-1:0]   rd_id_o,
    output logic [CNTF_W-1:0] rd_cnt_o
);

    logic [ID_W-1:0]   entry [NUM_SLOTS][SLOT_CAP];
    logic [CNTF_W-1:0] fill  [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        // Fill level: a clear wins over an append (the controller never
        // issues both to the same slot).
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fill[s] <= '0;
            end else if (clr_en_i && (clr_slot_i == SLOT_W'(s))) begin
                fill[s] <= '0;
            end else if (wr_en_i && (wr_slot_i == SLOT_W'(s))) begin
                fill[s] <= fill[s] + 1'b1;
            end
        end

        for (genvar c = 0; c < SLOT_CAP; c++) begin : g_ent
            always_ff @(posedge clk) begin
                if (wr_en_i && (wr_slot_i == SLOT_W'(s)) &&
                    (fill[s] == CNTF_W'(c))) begin
                    entry[s][c] <= wr_id_i;
                end
            end
        end
    end

    assign wr_cnt_o = fill[wr_slot_i];
    assign rd_cnt_o = fill[rd_slot_i];
    assign rd_id_o  = entry[rd_slot_i][rd_idx_i];

endmodule

// File: rtl/tw_ctrl.sv
// Service walk controller, schedule decode and error flags.
module tw_ctrl
    import tw_pkg::*;
#(
    parameter int SLOT_CAP = 4,
    parameter int SLOT_W   = 4,
    parameter int IDX_W    = 2,
    parameter int CNTF_W   = 3,
    parameter int PEND_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] now_slot_i,
    input  logic              sched_valid_i,
    input  logic [SLOT_W-1:0] sched_delay_i,
    input  logic [CNTF_W-1:0] wr_cnt_i,
    input  logic [CNTF_W-1:0] rd_cnt_i,
    input  logic              fire_ready_i,
    output logic              wr_en_o,
    output logic [SLOT_W-1:0] target_o,
    output logic              clr_en_o,
    output logic [SLOT_W-1:0] cur_slot_o,
    output logic [IDX_W-1:0]  rd_idx_o,
    output logic              fire_valid_o,
    output logic              err_full_o,
    output logic              err_zero_o,
    output logic [PEND_W-1:0] pend_o
);

    tw_state_e         state_q, state_d;
    logic [SLOT_W-1:0] svc_q;     // last fully serviced slot
    logic [SLOT_W-1:0] cur_q;     // slot being drained
    logic [IDX_W-1:0]  idx_q;     // entry being presented
    logic [PEND_W-1:0] pend_q;    // identifiers stored in the wheel
    logic [SLOT_W-1:0] base;
    logic              zero_req, full_req, pop, last_ent, wheel_empty;

    assign wheel_empty = (pend_q == '0);

    // Schedule base: fresh time sample when the wheel is empty, otherwise
    // the serviced position; during a drain, the slot being drained.
    always_comb begin
        if (state_q == TW_IDLE) begin
            base = wheel_empty ? now_slot_i : svc_q;
        end else begin
            base = cur_q;
        end
    end

    assign target_o = base + sched_delay_i;
    assign zero_req = sched_valid_i && (sched_delay_i == '0);
    assign full_req = sched_valid_i && !zero_req &&
                      (wr_cnt_i == CNTF_W'(SLOT_CAP));
    assign wr_en_o  = sched_valid_i && !zero_req && !full_req;
    assign pop      = (state_q == TW_EMIT) && fire_ready_i;
    assign last_ent = ((CNTF_W'(idx_q) + 1'b1) == rd_cnt_i);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TW_IDLE: begin
                if (!wheel_empty && (svc_q != now_slot_i)) begin
                    state_d = TW_LOAD;
                end
            end
            TW_LOAD: begin
                state_d = (rd_cnt_i == '0) ? TW_CLEAR : TW_EMIT;
            end
            TW_EMIT: begin
                if (pop && last_ent) begin
                    state_d = TW_CLEAR;
                end
            end
            TW_CLEAR: begin
                state_d = TW_IDLE;
            end
            default: state_d = TW_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TW_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Walk pointers, entry index, stored count and error flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            svc_q      <= '0;
            cur_q      <= '0;
            idx_q      <= '0;
            pend_q     <= '0;
            err_full_o <= 1'b0;
            err_zero_o <= 1'b0;
        end else begin
            if ((state_q == TW_IDLE) && wheel_empty) begin
                svc_q <= now_slot_i;
            end else if (state_q == TW_CLEAR) begin
                svc_q <= cur_q;
            end

            if ((state_q == TW_IDLE) && (state_d == TW_LOAD)) begin
                cur_q <= svc_q + 1'b1;
            end

            if (state_q == TW_LOAD) begin
                idx_q <= '0;
            end else if (pop) begin
                idx_q <= idx_q + 1'b1;
            end

            unique case ({wr_en_o, pop})
                2'b10:   pend_q <= pend_q + 1'b1;
                2'b01:   pend_q <= pend_q - 1'b1;
                default: pend_q <= pend_q;
            endcase

            err_full_o <= full_req;
            err_zero_o <= zero_req;
        end
    end

    // Outputs decoded from state
    always_comb begin
        fire_valid_o = (state_q == TW_EMIT);
        clr_en_o     = (state_q == TW_CLEAR);
        cur_slot_o   = cur_q;
        rd_idx_o     = idx_q;
        pend_o       = pend_q;
    end

endmodule

// File: rtl/timing_wheel_sched.sv
// Timing-wheel event scheduler top level.
module timing_wheel_sched #(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_CAP  = 4,
    parameter int ID_W      = 8,
    parameter int CNT_W     = 32,
    parameter int NUM_KINDS = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_KINDS-1:0]         tick_i,
    input  logic                         sched_valid_i,
    input  logic [ID_W-1:0]              sched_id_i,
    input  logic [$clog2(NUM_SLOTS)-1:0] sched_delay_i,
    output logic                         err_full_o,
    output logic                         err_zero_o,
    output logic                         fire_valid_o,
    output logic [ID_W-1:0]              fire_id_o,
    input  logic                         fire_ready_i,
    output logic [CNT_W-1:0]             time_o
);

    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int IDX_W  = (SLOT_CAP > 1) ? $clog2(SLOT_CAP) : 1;
    localparam int CNTF_W = $clog2(SLOT_CAP + 1);
    localparam int PEND_W = $clog2(NUM_SLOTS * SLOT_CAP + 1);

    logic [SLOT_W-1:0] now_slot;
    logic [SLOT_W-1:0] target;
    logic [SLOT_W-1:0] cur_slot;
    logic [IDX_W-1:0]  rd_idx;
    logic [CNTF_W-1:0] wr_cnt, rd_cnt;
    logic              wr_en, clr_en;
    logic [PEND_W-1:0] pend_cnt;

    tw_timebase #(
        .NUM_KINDS (NUM_KINDS),
        .CNT_W     (CNT_W),
        .SLOT_W    (SLOT_W)
    ) u_time (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .time_o     (time_o),
        .now_slot_o (now_slot)
    );

    tw_slot_store #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_CAP  (SLOT_CAP),
        .ID_W      (ID_W),
        .SLOT_W    (SLOT_W),
        .IDX_W     (IDX_W),
        .CNTF_W    (CNTF_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_slot_i  (target),
        .wr_id_i    (sched_id_i),
        .wr_cnt_o   (wr_cnt),
        .clr_en_i   (clr_en),
        .clr_slot_i (cur_slot),
        .rd_slot_i  (cur_slot),
        .rd_idx_i   (rd_idx),
        .rd_id_o    (fire_id_o),
        .rd_cnt_o   (rd_cnt)
    );

    tw_ctrl #(
        .SLOT_CAP (SLOT_CAP),
        .SLOT_W   (SLOT_W),
        .IDX_W    (IDX_W),
        .CNTF_W   (CNTF_W),
        .PEND_W   (PEND_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .now_slot_i    (now_slot),
        .sched_valid_i (sched_valid_i),
        .sched_delay_i (sched_delay_i),
        .wr_cnt_i      (wr_cnt),
        .rd_cnt_i      (rd_cnt),
        .fire_ready_i  (fire_ready_i),
        .wr_en_o       (wr_en),
        .target_o      (target),
        .clr_en_o      (clr_en),
        .cur_slot_o    (cur_slot),
        .rd_idx_o      (rd_idx),
        .fire_valid_o  (fire_valid_o),
        .err_full_o    (err_full_o),
        .err_zero_o    (err_zero_o),
        .pend_o        (pend_cnt)
    );

endmodule

// File: rtl/tw_sched_chk.sv
// Property checker for the timing-wheel scheduler, bound to the top.
module tw_sched_chk #(
    parameter int ID_W   = 8,
    parameter int SLOT_W = 4,
    parameter int PEND_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sched_valid_i,
    input logic [SLOT_W-1:0] sched_delay_i,
    input logic              err_full_o,
    input logic              err_zero_o,
    input logic              fire_valid_o,
    input logic [ID_W-1:0]   fire_id_o,
    input logic              fire_ready_i,
    input logic [PEND_W-1:0] pend_cnt
);

    // R1: no presentation while reset is applied
    always_comb begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!fire_valid_o);
        end
    end

    // R6: presented identifier held under backpressure
    assert_fire_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_valid_o && !fire_ready_i) |=> (fire_valid_o && $stable(fire_id_o)));

    // R9: zero-delay request flagged next cycle
    assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_valid_i && (sched_delay_i == '0)) |=> err_zero_o);

    // R9: zero flag only follows a zero-delay request
    assert_zero_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_zero_o |-> $past(sched_valid_i && (sched_delay_i == '0)));

    // R8: full flag only follows a nonzero-delay request
    assert_full_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_full_o |-> $past(sched_valid_i && (sched_delay_i != '0)));

    // R8: the two drop reasons are exclusive
    assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_full_o && err_zero_o));

    // R4: nothing presented from an empty wheel
    assert_fire_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire_valid_o |-> (pend_cnt != '0));

    // R7: each handshake removes one stored identifier
    assert_pop_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_valid_o && fire_ready_i && !sched_valid_i) |=>
            (pend_cnt == $past(pend_cnt) - 1'b1));

endmodule

bind timing_wheel_sched tw_sched_chk #(
    .ID_W   (ID_W),
    .SLOT_W (SLOT_W),
    .PEND_W (PEND_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sched_valid_i (sched_valid_i),
    .sched_delay_i (sched_delay_i),
    .err_full_o    (err_full_o),
    .err_zero_o    (err_zero_o),
    .fire_valid_o  (fire_valid_o),
    .fire_id_o     (fire_id_o),
    .fire_ready_i  (fire_ready_i),
    .pend_cnt      (pend_cnt)
);

// File: tb/tb_timing_wheel_sched.sv
`timescale 1ns/1ps
module tb_timing_wheel_sched;

    localparam int NS    = 16;
    localparam int KINDS = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [KINDS-1:0] tick = '0;
    logic             sv = 1'b0;
    logic [7:0]       sid = '0;
    logic [3:0]       sdly = '0;
    logic             err_full, err_zero, fvalid, fready;
    logic [7:0]       fid;
    logic [31:0]      tnow;

    always #2.5 clk = ~clk;

    timing_wheel_sched dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .sched_valid_i(sv), .sched_id_i(sid), .sched_delay_i(sdly),
        .err_full_o(err_full), .err_zero_o(err_zero),
        .fire_valid_o(fvalid), .fire_id_o(fid), .fire_ready_i(fready),
        .time_o(tnow)
    );

    int n_chk = 0;
    int n_bad = 0;
    int step  = 0;
    logic [7:0] log_id [64];
    int         log_step [64];
    int         log_n = 0;

    // Table: {id, delay, expected step of emission}
    localparam logic [23:0] VEC [8] = '{
        {8'h11, 8'd3,  8'd3},
        {8'h12, 8'd1,  8'd1},
        {8'h13, 8'd3,  8'd3},
        {8'h14, 8'd7,  8'd7},
        {8'h15, 8'd15, 8'd15},
        {8'h16, 8'd1,  8'd1},
        {8'h17, 8'd9,  8'd9},
        {8'h18, 8'd3,  8'd3}
    };

    always @(negedge clk) begin
        if (rst_n && fvalid && fready && log_n < 64) begin
            log_id[log_n]   <= fid;
            log_step[log_n] <= step;
            log_n           <= log_n + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sched(input logic [7:0] id, input logic [3:0] d,
                         output logic f, output logic z);
        sv = 1'b1; sid = id; sdly = d;
        @(posedge clk); #1;
        sv = 1'b0;
        f = err_full; z = err_zero;
    endtask

    task automatic tick_n(input logic [KINDS-1:0] m, input int units, input int waitc);
        tick = m;
        @(posedge clk); #1;
        tick = '0;
        step += units;
        repeat (waitc) @(posedge clk);
        #1;
    endtask

    task automatic advance(input int n);
        for (int i = 0; i < n; i++) tick_n(5'b00001, 1, 24);
    endtask

    function automatic int find(input logic [7:0] id);
        for (int i = 0; i < log_n; i++) if (log_id[i] == id) return i;
        return -1;
    endfunction

    bit done = 0;

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic f, z;
        int mark, p0, p1, p2;
        fready = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(fvalid == 1'b0, "R1 fire_valid", fvalid, 0);
        check(err_full == 1'b0 && err_zero == 1'b0, "R1 errs", {err_full, err_zero}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(tnow == 0, "R1 time", tnow, 0);

        // Table walk: schedule every row from a settled wheel (R3)
        for (int i = 0; i < 8; i++) begin
            sched(VEC[i][23:16], VEC[i][11:8], f, z);
            check(!f && !z, "R3 accepted", {f, z}, 0);
        end
        step = 0;
        advance(16);
        for (int i = 0; i < 8; i++) begin
            p0 = find(VEC[i][23:16]);
            check(p0 >= 0, "R4 emitted", p0, 0);
            if (p0 >= 0)
                check(log_step[p0] == int'(VEC[i][7:0]), "R4 step", log_step[p0], VEC[i][7:0]);
        end
        check(log_n == 8, "R4 exactly once", log_n, 8);
        p0 = find(8'h11); p1 = find(8'h13); p2 = find(8'h18);
        check(p0 < p1 && p1 < p2, "R7 slot order", p1, p0 + 1);
        check(tnow == 16, "R2 time single ticks", tnow, 16);

        // Wrap-around catch-up (R5)
        advance(12);
        sched(8'h21, 4'd6, f, z);
        sched(8'h22, 4'd3, f, z);
        mark = log_n;
        tick_n(5'b11111, 5, 40);
        check(tnow == 33, "R2 multi-kind jump", tnow, 33);
        check(log_n == mark + 1, "R5 crossed slots only", log_n, mark + 1);
        check(log_id[mark] == 8'h22, "R5 wrap slot fired", log_id[mark], 8'h22);
        tick_n(5'b00001, 1, 24);
        check(log_n == mark + 2 && log_id[mark + 1] == 8'h21, "R5 next slot after wrap",
              log_id[mark + 1], 8'h21);

        // Capacity overflow and backpressure (R8, R6, R7)
        fready = 1'b0;
        for (int i = 0; i < 5; i++) begin
            sched(8'h31 + 8'(i), 4'd2, f, z);
            check(f == (i == 4), "R8 full flag", f, (i == 4));
        end
        mark = log_n;
        tick_n(5'b00001, 1, 24);
        tick_n(5'b00001, 1, 24);
        check(fvalid == 1'b1 && fid == 8'h31, "R6 presented under stall", fid, 8'h31);
        repeat (5) @(posedge clk);
        #1;
        check(fvalid == 1'b1 && fid == 8'h31, "R6 held under stall", fid, 8'h31);
        fready = 1'b1;
        repeat (20) @(posedge clk);
        #1;
        check(log_n == mark + 4, "R8 dropped fifth", log_n, mark + 4);
        for (int i = 0; i < 4; i++)
            check(log_id[mark + i] == 8'h31 + 8'(i), "R7 insertion order",
                  log_id[mark + i], 8'h31 + 8'(i));
        check(fvalid == 1'b0, "R7 slot drained", fvalid, 0);

        // Zero delay, then a full revolution (R9, R7)
        sched(8'h41, 4'd0, f, z);
        check(z == 1'b1 && f == 1'b0, "R9 zero flag", {f, z}, 1);
        mark = log_n;
        advance(16);
        check(log_n == mark, "R9 zero-delay never fires", log_n, mark);
        check(find(8'h35) < 0, "R7 emptied slot stays empty", find(8'h35), -1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule